// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block assembles an instrument's top-level status byte from five summary flags that lower status structures produce: a pending-error flag, a questionable-condition summary, an output-data-ready flag, a standard-event summary and an operation summary. Each flag is registered into its own bit of the byte. Bits 0 and 1 are reserved and always read as zero. Bit 6 is not stored. It is a master summary, derived each cycle from the other bits of the byte and a host-writable service-request enable mask.

The block raises a service-request line when an enabled status bit changes from 0 to 1. A bit that simply stays high does not raise it. The line stays asserted until the host acknowledges it, or until the host writes a mask that enables none of the summary bits. The host can always read the status byte and the mask at the output ports. Reading clears nothing, because each stored bit follows its source flag.

Top module: `stb_srq_unit`

## Requirements
- R1: One clock after the inputs are sampled, status byte bits 2, 3, 4, 5 and 7 equal err_pending_i, quest_sum_i, data_ready_i, event_sum_i and oper_sum_i respectively, for as long as those inputs hold.
- R2: Status byte bits 0 and 1 always read as 0.
- R3: Status byte bit 6 is 1 exactly when some bit among 2, 3, 4, 5 and 7 of the byte is 1 and the same bit of the enable mask is 1.
- R4: Mask bit 6 has no effect on status byte bit 6 or on srq_o, whatever value it holds.
- R5: When mask_we_i is high at a clock edge, mask_o shows mask_wdata_i unchanged, all 8 bits, from that edge on.
- R6: When a status bit among 2, 3, 4, 5 and 7 changes from 0 to 1, and its enable bit was 1 before that edge, srq_o is 1 in the same cycle the byte shows the new bit.
- R7: A status bit that stays high, or a bit whose enable bit is 0, does not raise srq_o.
- R8: Once raised, srq_o stays 1 until an edge with srq_ack_i high, or an edge where a mask write enables none of bits 2, 3, 4, 5 and 7. A qualifying 0-to-1 change at that same edge keeps srq_o at 1.
- R9: Reset clears the status byte, the enable mask and srq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pending_i | input | 1 | Error queue holds at least one entry |
| quest_sum_i | input | 1 | Questionable-condition summary |
| data_ready_i | input | 1 | Readable data waits in the output buffer |
| event_sum_i | input | 1 | Standard-event summary |
| oper_sum_i | input | 1 | Operation summary |
| mask_we_i | input | 1 | Write strobe for the enable mask |
| mask_wdata_i | input | 8 | New enable mask value |
| srq_ack_i | input | 1 | Host acknowledge; clears the request |
| status_byte_o | output | 8 | Assembled status byte with master summary in bit 6 |
| mask_o | output | 8 | Enable mask readback |
| srq_o | output | 1 | Service request line |

## Verification
On every cycle the assertions check the reserved zero bits, that bit 6 agrees with the byte and mask visible at the ports, the one-cycle tracking of each flag, mask write-back, that an enabled rising edge raises the request, and that the request holds until it is acknowledged or cleared. Some behaviours need a chosen history to show up, and only the bench scenarios cover them. These are that a bit held high or disabled never raises the request, that mask bit 6 alone produces nothing, and that a rising edge coinciding with an acknowledge keeps the line high. A behavioural reference model runs alongside the bench and is compared every clock over directed and random stimulus.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int SB_W     = 8;
    localparam int B_ERR    = 2;
    localparam int B_QUES   = 3;
    localparam int B_RDY    = 4;
    localparam int B_EVT    = 5;
    localparam int B_MSS    = 6;
    localparam int B_OPER   = 7;
    // bits that take part in the summary and in edge detection
    localparam logic [SB_W-1:0] SUM_BITS =
        (SB_W'(1) << B_ERR) | (SB_W'(1) << B_QUES) | (SB_W'(1) << B_RDY) |
        (SB_W'(1) << B_EVT) | (SB_W'(1) << B_OPER);

    typedef struct packed {
        logic [SB_W-1:0] sb;
    } samp_state_t;

    typedef struct packed {
        logic [SB_W-1:0] mask;
    } mask_state_t;

    typedef struct packed {
        logic srq;
    } srq_state_t;
endpackage

// File: rtl/stb_sampler.sv
module stb_sampler
    import stb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err_pending_i,
    input  logic            quest_sum_i,
    input  logic            data_ready_i,
    input  logic            event_sum_i,
    input  logic            oper_sum_i,
    output logic [SB_W-1:0] sb_q_o,
    output logic [SB_W-1:0] rise_o
);
    samp_state_t st_d, st_q;
    logic [SB_W-1:0] nxt;

    always_comb begin
        nxt         = '0;
        nxt[B_ERR]  = err_pending_i;
        nxt[B_QUES] = quest_sum_i;
        nxt[B_RDY]  = data_ready_i;
        nxt[B_EVT]  = event_sum_i;
        nxt[B_OPER] = oper_sum_i;
        st_d        = st_q;
        st_d.sb     = nxt & SUM_BITS;
        rise_o      = st_d.sb & ~st_q.sb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sb_q_o = st_q.sb;
endmodule

// File: rtl/stb_mask_reg.sv
module stb_mask_reg
    import stb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [SB_W-1:0] wdata_i,
    output logic [SB_W-1:0] mask_q_o,
    output logic [SB_W-1:0] eff_mask_o,
    output logic            clear_o
);
    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = wdata_i;
        clear_o = we_i && ((wdata_i & SUM_BITS) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q_o   = st_q.mask;
    assign eff_mask_o = st_q.mask & SUM_BITS;
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl
    import stb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] rise_i,
    input  logic [SB_W-1:0] eff_mask_i,
    input  logic [SB_W-1:0] sb_q_i,
    input  logic            ack_i,
    input  logic            clear_i,
    output logic            mss_o,
    output logic            srq_o
);
    srq_state_t st_d, st_q;
    logic trig;

    always_comb begin
        trig     = |(rise_i & eff_mask_i);
        st_d     = st_q;
        if (ack_i || clear_i) st_d.srq = 1'b0;
        if (trig)             st_d.srq = 1'b1;
        mss_o    = |(sb_q_i & eff_mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign srq_o = st_q.srq;
endmodule

// File: rtl/stb_srq_unit.sv
module stb_srq_unit
    import stb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err_pending_i,
    input  logic            quest_sum_i,
    input  logic            data_ready_i,
    input  logic            event_sum_i,
    input  logic            oper_sum_i,
    input  logic            mask_we_i,
    input  logic [SB_W-1:0] mask_wdata_i,
    input  logic            srq_ack_i,
    output logic [SB_W-1:0] status_byte_o,
    output logic [SB_W-1:0] mask_o,
    output logic            srq_o
);
    logic [SB_W-1:0] sb_q, rise, eff_mask;
    logic            mask_clear, mss;

    stb_sampler u_samp (
        .clk(clk), .rst_n(rst_n),
        .err_pending_i(err_pending_i), .quest_sum_i(quest_sum_i),
        .data_ready_i(data_ready_i), .event_sum_i(event_sum_i),
        .oper_sum_i(oper_sum_i),
        .sb_q_o(sb_q), .rise_o(rise)
    );

    stb_mask_reg u_mask (
        .clk(clk), .rst_n(rst_n),
        .we_i(mask_we_i), .wdata_i(mask_wdata_i),
        .mask_q_o(mask_o), .eff_mask_o(eff_mask), .clear_o(mask_clear)
    );

    stb_srq_ctrl u_srq (
        .clk(clk), .rst_n(rst_n),
        .rise_i(rise), .eff_mask_i(eff_mask), .sb_q_i(sb_q),
        .ack_i(srq_ack_i), .clear_i(mask_clear),
        .mss_o(mss), .srq_o(srq_o)
    );

    always_comb begin
        status_byte_o        = sb_q;
        status_byte_o[B_MSS] = mss;
    end
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk
    import stb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            err_pending_i,
    input logic            quest_sum_i,
    input logic            data_ready_i,
    input logic            event_sum_i,
    input logic            oper_sum_i,
    input logic            mask_we_i,
    input logic [SB_W-1:0] mask_wdata_i,
    input logic            srq_ack_i,
    input logic [SB_W-1:0] status_byte_o,
    input logic [SB_W-1:0] mask_o,
    input logic            srq_o
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic [SB_W-1:0] sb_nomss;
    assign sb_nomss = status_byte_o & SUM_BITS;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte_o[1:0] == 2'b00);

    // R3
    mss_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte_o[B_MSS] == (|(sb_nomss & mask_o & SUM_BITS)));

    // R1
    flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (status_byte_o[B_ERR]  == $past(err_pending_i) &&
                     status_byte_o[B_QUES] == $past(quest_sum_i) &&
                     status_byte_o[B_RDY]  == $past(data_ready_i) &&
                     status_byte_o[B_EVT]  == $past(event_sum_i) &&
                     status_byte_o[B_OPER] == $past(oper_sum_i)));

    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mask_we_i)) |-> mask_o == $past(mask_wdata_i));

    // R6
    srq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (|(sb_nomss & ~($past(status_byte_o) & SUM_BITS) & $past(mask_o))))
        |-> srq_o);

    // R8
    srq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(srq_o) && !$past(srq_ack_i) &&
         !($past(mask_we_i) && (($past(mask_wdata_i) & SUM_BITS) == '0)))
        |-> srq_o);
endmodule

bind stb_srq_unit stb_srq_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .err_pending_i(err_pending_i), .quest_sum_i(quest_sum_i),
    .data_ready_i(data_ready_i), .event_sum_i(event_sum_i),
    .oper_sum_i(oper_sum_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .srq_ack_i(srq_ack_i),
    .status_byte_o(status_byte_o), .mask_o(mask_o), .srq_o(srq_o)
);

// File: tb/stb_srq_unit_tb.sv
`timescale 1ns/1ps
module stb_srq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_pending_i = 0, quest_sum_i = 0, data_ready_i = 0;
    logic       event_sum_i = 0, oper_sum_i = 0;
    logic       mask_we_i = 0, srq_ack_i = 0;
    logic [7:0] mask_wdata_i = 0;
    logic [7:0] status_byte_o, mask_o;
    logic       srq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    stb_srq_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .err_pending_i(err_pending_i), .quest_sum_i(quest_sum_i),
        .data_ready_i(data_ready_i), .event_sum_i(event_sum_i),
        .oper_sum_i(oper_sum_i), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .srq_ack_i(srq_ack_i),
        .status_byte_o(status_byte_o), .mask_o(mask_o), .srq_o(srq_o)
    );

    // behavioural reference model
    int   sum_idx[5] = '{2, 3, 4, 5, 7};
    logic [7:0] m_sb = 0, m_mask = 0;
    logic       m_srq = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sb <= 0; m_mask <= 0; m_srq <= 0;
        end else begin
            logic [7:0] nsb;
            bit rise, anyen;
            nsb = 0;
            nsb[2] = err_pending_i; nsb[3] = quest_sum_i; nsb[4] = data_ready_i;
            nsb[5] = event_sum_i;   nsb[7] = oper_sum_i;
            rise = 0; anyen = 0;
            foreach (sum_idx[k]) begin
                if (nsb[sum_idx[k]] && !m_sb[sum_idx[k]] && m_mask[sum_idx[k]]) rise = 1;
                if (mask_wdata_i[sum_idx[k]]) anyen = 1;
            end
            m_srq  <= rise || (m_srq && !srq_ack_i && !(mask_we_i && !anyen));
            m_mask <= mask_we_i ? mask_wdata_i : m_mask;
            m_sb   <= nsb;
        end
    end

    function automatic logic model_mss();
        logic r = 0;
        foreach (sum_idx[k]) if (m_sb[sum_idx[k]] && m_mask[sum_idx[k]]) r = 1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            logic [7:0] exp_sb;
            exp_sb = m_sb;
            exp_sb[6] = model_mss();
            chk(status_byte_o[1:0] == 2'b00, "R2 reserved bits", status_byte_o[1:0], 0);
            chk((status_byte_o & 8'hBC) == (exp_sb & 8'hBC), "R1 flag bits",
                status_byte_o & 8'hBC, exp_sb & 8'hBC);
            chk(status_byte_o[6] == exp_sb[6], "R3 master summary", status_byte_o[6], exp_sb[6]);
            chk(mask_o == m_mask, "R5 mask readback", mask_o, m_mask);
            chk(srq_o == m_srq, "R6/R8 srq model", srq_o, m_srq);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic set_flags(input logic [4:0] f);
        {oper_sum_i, event_sum_i, data_ready_i, quest_sum_i, err_pending_i} = f;
    endtask

    task automatic write_mask(input logic [7:0] v);
        mask_we_i = 1; mask_wdata_i = v; tick(); mask_we_i = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        set_flags(5'b11111);
        write_mask(8'hFF);           // during reset: ignored
        repeat (2) tick();
        // R9: reset state
        chk(status_byte_o == 0, "R9 byte in reset", status_byte_o, 0);
        chk(mask_o == 0, "R9 mask in reset", mask_o, 0);
        chk(srq_o == 0, "R9 srq in reset", srq_o, 0);
        set_flags(0);
        rst_n = 1; cmp_en = 1;
        tick();

        // R1: each flag alone
        for (int i = 0; i < 5; i++) begin
            set_flags(5'(1 << i)); tick();
            chk(status_byte_o == (8'(1) << sum_idx[i]), "R1 single flag",
                status_byte_o, 8'(1) << sum_idx[i]);
        end
        set_flags(0); tick();

        // R6: enable bit 4, raise data ready
        write_mask(8'h10);
        data_ready_i = 1; tick();
        chk(srq_o == 1, "R6 srq raised", srq_o, 1);
        chk(status_byte_o == 8'h50, "R3 mss with bit4", status_byte_o, 8'h50);
        // R7: held level does not retrigger after ack
        srq_ack_i = 1; tick(); srq_ack_i = 0;
        chk(srq_o == 0, "R8 ack clears", srq_o, 0);
        repeat (3) tick();
        chk(srq_o == 0, "R7 held level no srq", srq_o, 0);
        // R7: disabled bit rising
        quest_sum_i = 1; tick();
        chk(srq_o == 0, "R7 disabled bit no srq", srq_o, 0);
        set_flags(0); tick();

        // R4: only mask bit 6 set
        write_mask(8'h40);
        chk(mask_o == 8'h40, "R5 mask bit6 readback", mask_o, 8'h40);
        set_flags(5'b11111); tick();
        chk(status_byte_o[6] == 0, "R4 bit6 mask no mss", status_byte_o[6], 0);
        chk(srq_o == 0, "R4 bit6 mask no srq", srq_o, 0);
        set_flags(0); tick();

        // R8: hold, then clear via empty mask
        write_mask(8'h84);
        oper_sum_i = 1; tick();
        chk(srq_o == 1, "R6 oper rise", srq_o, 1);
        oper_sum_i = 0; repeat (3) tick();
        chk(srq_o == 1, "R8 srq held", srq_o, 1);
        write_mask(8'h43);
        chk(srq_o == 0, "R8 empty mask clears", srq_o, 0);

        // R8: ack and new rise at the same edge
        write_mask(8'h0C);
        err_pending_i = 1; tick();
        err_pending_i = 0; tick();
        err_pending_i = 1; srq_ack_i = 1; tick(); srq_ack_i = 0;
        chk(srq_o == 1, "R8 rise beats ack", srq_o, 1);
        set_flags(0); tick();

        // random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            set_flags(5'($urandom));
            srq_ack_i    = ($urandom % 6) == 0;
            mask_we_i    = ($urandom % 5) == 0;
            mask_wdata_i = 8'($urandom);
        end
        @(negedge clk);
        mask_we_i = 0; srq_ack_i = 0;
        repeat (2) tick();
        done = 1;
        summary();
        $finish;
    end
endmodule